// File: doc/BRIEF.md
# Infrared Carrier Generator with Transmit Indicator

This block produces the modulated drive for an infrared emitter. A 3-bit select value chooses how far the system clock is divided to form the carrier. An envelope bit gates that carrier into bursts. The remote output is active high and carries the gated carrier. A second, active-low output lights a transmit indicator for as long as the envelope is active.

At a 455 kHz system clock, the divide-by-12 setting gives a carrier of about 38 kHz. Its period is 12 clocks, about 26.4 µs, and each high phase lasts 4 clocks, one third of the period. Every burst starts from the beginning of a high phase. The select value is captured when a burst begins and is held until the burst ends, so a change made mid-burst never shortens or stretches a carrier cycle.

Both outputs are registered. Each one reflects the envelope and select values that were sampled at the previous clock edge.

Top module: `ir_carrier_gen`

## Requirements
- R1: The select value picks the carrier: 0 = clock rate (seen at the register output as a constant high during a burst), 1 = divide by 2, 2 = divide by 8, 3 = divide by 12, 4 = divide by 16, 5 = divide by 24, 6 and 7 = no carrier (output held high while the envelope is active).
- R2: While the synchronous reset is sampled high, `rem_out` becomes 0 and `ind_n` becomes 1 at the next clock edge, even in the middle of a burst.
- R3: For a divide ratio N of 8 or more, each carrier period lasts N clocks, and its high phase lasts round(N/3) clocks: 3, 4, 5 and 8 for N = 8, 12, 16 and 24. Divide by 2 alternates one clock high with one clock low.
- R4: The first clock edge that samples the envelope high starts the divider at the beginning of its high phase. `rem_out` is therefore high on the first output cycle of every burst and stays high for a full high phase.
- R5: The clock edge that samples the envelope low drives `rem_out` to 0 and returns the divider to its start. This applies even in the middle of a high phase.
- R6: `ind_n` is 0 exactly in the cycles that follow an edge at which the envelope was sampled high, and 1 otherwise.
- R7: A select value is taken only at the edge that starts a burst. Changes to the select during a burst have no effect until the envelope has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| car_sel | input | 3 | Carrier select value (encoding in R1) |
| env_en | input | 1 | Envelope; high means emit a burst |
| rem_out | output | 1 | Gated carrier to the emitter, active high |
| ind_n | output | 1 | Transmit indicator, active low |

## Verification
Every result appears one clock after the edge that samples its cause. A burst's first high cycle, the drop after the envelope falls, the indicator change and the reset values each land in the cycle after the edge at which `env_en`, `car_sel` or `rst` was seen. The bench drives its inputs on the falling edge. A behavioural model updates at the rising edge from those same inputs, and both outputs are compared with the model at the next falling edge. Each check is therefore made exactly one register stage after its stimulus, with no skew allowance.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  typedef enum logic [2:0] {
    CS_FULL  = 3'd0,
    CS_HALF  = 3'd1,
    CS_DIV8  = 3'd2,
    CS_DIV12 = 3'd3,
    CS_DIV16 = 3'd4,
    CS_DIV24 = 3'd5,
    CS_HOLD  = 3'd6,
    CS_HOLD2 = 3'd7
  } car_sel_e;

  // Divide ratio behind a select code; steady settings use a ratio of 1.
  function automatic int unsigned ratio_of(
    input logic [2:0] sel,
    input int unsigned r2, input int unsigned r8, input int unsigned r12,
    input int unsigned r16, input int unsigned r24);
    case (car_sel_e'(sel))
      CS_HALF:  return r2;
      CS_DIV8:  return r8;
      CS_DIV12: return r12;
      CS_DIV16: return r16;
      CS_DIV24: return r24;
      default:  return 1;
    endcase
  endfunction

  // High-phase length: a third of the period rounded, never below one clock.
  function automatic int unsigned high_len(input int unsigned n);
    if (n <= 2) return 1;
    return (n + 1) / 3;
  endfunction

  function automatic logic is_steady(input logic [2:0] sel);
    return sel[2] & sel[1];
  endfunction

  function automatic int unsigned max5(
    input int unsigned a, input int unsigned b, input int unsigned c,
    input int unsigned d, input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/ir_burst_ctrl.sv
module ir_burst_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       env_en,
  input  logic [2:0] car_sel,
  output logic       burst_on,
  output logic       burst_start,
  output logic [2:0] sel_act
);
  logic       env_q;
  logic [2:0] sel_q;

  // A new burst takes the live select; an ongoing one keeps its captured value.
  assign burst_on    = env_q;
  assign burst_start = env_en & ~env_q;
  assign sel_act     = env_q ? sel_q : car_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      env_q <= 1'b0;
      sel_q <= '0;
    end else begin
      env_q <= env_en;
      sel_q <= sel_act;
    end
  end
endmodule

// File: rtl/ir_car_div.sv
module ir_car_div #(
  parameter int unsigned RATIO_2  = 2,
  parameter int unsigned RATIO_8  = 8,
  parameter int unsigned RATIO_12 = 12,
  parameter int unsigned RATIO_16 = 16,
  parameter int unsigned RATIO_24 = 24,
  parameter int unsigned PH_W     = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            env_en,
  input  logic [2:0]      sel_act,
  output logic [PH_W-1:0] phase,
  output logic            wrap,
  output logic            car_high
);
  import ir_carrier_pkg::*;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] hi_len;
  int unsigned     n_sel;

  always_comb begin
    n_sel   = ratio_of(sel_act, RATIO_2, RATIO_8, RATIO_12, RATIO_16, RATIO_24);
    last_ph = PH_W'(n_sel - 1);
    hi_len  = PH_W'(high_len(n_sel));
  end

  assign phase    = ph_q;
  assign wrap     = (ph_q == last_ph);
  assign car_high = is_steady(sel_act) | (ph_q < hi_len);

  // The counter sits at zero whenever the envelope is low, so each burst
  // begins on the first clock of a high phase.
  always_ff @(posedge clk) begin
    if (rst || !env_en) ph_q <= '0;
    else if (wrap)      ph_q <= '0;
    else                ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/ir_out_stage.sv
module ir_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic env_en,
  input  logic car_high,
  output logic rem_out,
  output logic ind_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_out <= 1'b0;
      ind_n   <= 1'b1;
    end else begin
      rem_out <= env_en & car_high;
      ind_n   <= ~env_en;
    end
  end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int unsigned RATIO_2  = 2,
  parameter int unsigned RATIO_8  = 8,
  parameter int unsigned RATIO_12 = 12,
  parameter int unsigned RATIO_16 = 16,
  parameter int unsigned RATIO_24 = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] car_sel,
  input  logic       env_en,
  output logic       rem_out,
  output logic       ind_n
);
  import ir_carrier_pkg::*;

  localparam int unsigned RATIO_MAX =
    max5(RATIO_2, RATIO_8, RATIO_12, RATIO_16, RATIO_24);
  localparam int unsigned PH_W = $clog2(RATIO_MAX + 1);

  logic            burst_on;
  logic            burst_start;
  logic [2:0]      sel_act;
  logic [PH_W-1:0] phase;
  logic            wrap;
  logic            car_high;

  ir_burst_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .env_en      (env_en),
    .car_sel     (car_sel),
    .burst_on    (burst_on),
    .burst_start (burst_start),
    .sel_act     (sel_act)
  );

  ir_car_div #(
    .RATIO_2  (RATIO_2),
    .RATIO_8  (RATIO_8),
    .RATIO_12 (RATIO_12),
    .RATIO_16 (RATIO_16),
    .RATIO_24 (RATIO_24),
    .PH_W     (PH_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .env_en   (env_en),
    .sel_act  (sel_act),
    .phase    (phase),
    .wrap     (wrap),
    .car_high (car_high)
  );

  ir_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .env_en   (env_en),
    .car_high (car_high),
    .rem_out  (rem_out),
    .ind_n    (ind_n)
  );
endmodule

// File: rtl/ir_carrier_chk.sv
module ir_carrier_chk #(
  parameter int unsigned PH_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            env_en,
  input logic            rem_out,
  input logic            ind_n,
  input logic            burst_on,
  input logic            burst_start,
  input logic [2:0]      sel_act,
  input logic [PH_W-1:0] phase,
  input logic            wrap
);
  a_r2_reset_outputs: assert property (@(posedge clk)
    rst |=> (!rem_out && ind_n));

  a_r5_env_low_mutes: assert property (@(posedge clk) disable iff (rst)
    !env_en |=> !rem_out);

  a_r5_phase_cleared: assert property (@(posedge clk) disable iff (rst)
    !env_en |=> (phase == '0));

  a_r6_ind_on: assert property (@(posedge clk) disable iff (rst)
    env_en |=> !ind_n);

  a_r6_ind_off: assert property (@(posedge clk) disable iff (rst)
    !env_en |=> ind_n);

  a_r4_start_phase: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> (phase == '0));

  a_r4_start_high: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> rem_out);

  a_r3_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
    (env_en && wrap) |=> (phase == '0));

  a_r7_sel_held: assert property (@(posedge clk) disable iff (rst)
    (burst_on && env_en) |=> $stable(sel_act));
endmodule

bind ir_carrier_gen ir_carrier_chk #(.PH_W(PH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .env_en      (env_en),
  .rem_out     (rem_out),
  .ind_n       (ind_n),
  .burst_on    (burst_on),
  .burst_start (burst_start),
  .sel_act     (sel_act),
  .phase       (phase),
  .wrap        (wrap)
);

// File: tb/ir_carrier_gen_test.sv
module ir_carrier_gen_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] car_sel;
  logic       env_en;
  logic       rem_out;
  logic       ind_n;

  always #10 clk = ~clk;

  ir_carrier_gen uut (
    .clk     (clk),
    .rst     (rst),
    .car_sel (car_sel),
    .env_en  (env_en),
    .rem_out (rem_out),
    .ind_n   (ind_n)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R2";
  bit    chk_en  = 1'b0;

  // Behavioural reference state
  int   m_in_burst = 0;
  int   m_sel      = 0;
  int   m_ph       = 0;
  logic exp_rem    = 1'b0;
  logic exp_ind    = 1'b1;

  function automatic int m_div(input int s);
    case (s)
      1: return 2;
      2: return 8;
      3: return 12;
      4: return 16;
      5: return 24;
      default: return 1;
    endcase
  endfunction

  function automatic int m_high(input int n);
    int h;
    h = (n * 10 / 3 + 5) / 10;
    return (h < 1) ? 1 : h;
  endfunction

  always @(posedge clk) begin
    int s, p, n;
    if (rst) begin
      m_in_burst = 0; m_sel = 0; m_ph = 0;
      exp_rem = 1'b0; exp_ind = 1'b1;
    end else begin
      s = m_in_burst ? m_sel : int'(car_sel);
      p = m_in_burst ? m_ph : 0;
      n = m_div(s);
      exp_rem = env_en && ((s >= 6) || (p < m_high(n)));
      exp_ind = !env_en;
      m_sel = s;
      m_ph = env_en ? ((p + 1) % n) : 0;
      m_in_burst = env_en ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      n_tests++;
      if (rem_out !== exp_rem) begin
        n_fail++;
        $display("FAIL %s rem_out at %0t: got %b expected %b", cur_req, $time, rem_out, exp_rem);
      end
      n_tests++;
      if (ind_n !== exp_ind) begin
        n_fail++;
        $display("FAIL R6 ind_n at %0t: got %b expected %b", $time, ind_n, exp_ind);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; env_en = 1'b0; car_sel = 3'd0;
    step(2);
    // R2: reset values of both outputs
    n_tests++;
    if (rem_out !== 1'b0 || ind_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 reset state: got %b%b expected 01", rem_out, ind_n);
    end
    chk_en = 1'b1;
    rst = 1'b0;
    step(2);

    // R1 and R3: every select code over a long burst
    for (int s = 0; s < 8; s++) begin
      cur_req = (s == 0 || s >= 6) ? "R1" : "R3";
      car_sel = 3'(s);
      env_en = 1'b1;
      step(55);
      env_en = 1'b0;
      step(4);
    end

    // R4: short bursts each begin with a full high phase
    cur_req = "R4";
    car_sel = 3'd3;
    for (int k = 1; k <= 6; k++) begin
      env_en = 1'b1; step(k);
      env_en = 1'b0; step(2);
    end

    // R5: envelope dropped mid high phase, then restarted
    cur_req = "R5";
    car_sel = 3'd5;
    env_en = 1'b1; step(3);
    env_en = 1'b0; step(1);
    env_en = 1'b1; step(30);
    env_en = 1'b0; step(3);

    // R7: select change during a burst is deferred
    cur_req = "R7";
    car_sel = 3'd3;
    env_en = 1'b1; step(5);
    car_sel = 3'd1; step(30);
    car_sel = 3'd6; step(7);
    car_sel = 3'd1;
    env_en = 1'b0; step(1);
    env_en = 1'b1; step(12);
    env_en = 1'b0; step(3);

    // R2: reset in the middle of a burst
    cur_req = "R2";
    car_sel = 3'd2;
    env_en = 1'b1; step(5);
    rst = 1'b1; step(2);
    rst = 1'b0; step(20);
    env_en = 1'b0; step(3);

    chk_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule